// File: doc/BRIEF.md
# CCD Binning Readout Sequencer

This block drives the readout clocking of a charge-coupled sensor. Charge is summed on the chip in both directions. It produces vertical (parallel) shift pulses, horizontal (serial) shift pulses, output-node reset pulses and a one-cycle convert strobe for the digitizer. Configuration inputs set the array size, the pulse width, a settle delay and up to `NUM_ROI` regions of interest. Each region has its own start row, start column, count of binned rows and binned columns, and its own horizontal and vertical bin factor.

A `start` pulse launches one frame. The regions are handled in index order. Rows above a region are moved into the serial register and then cleared out with a full-width horizontal flush. Each binned row begins with its vertical shifts. Columns to the left and right of a region are shifted out without conversion. Within the region, every super pixel gets a node reset, its group of horizontal shifts, a settle wait and a convert strobe. The block counts the converted super pixels and pulses `frame_done` at the end of the frame. Configuration inputs must stay stable while a frame runs.

Top module: `ccd_bin_seq`

## Requirements
- R1: After reset, all pulse outputs, `convert`, `frame_done` and `cfg_err` are low and `spix_count` is zero.
- R2: Each binned row of a region is preceded by exactly `by` vertical shift pulses, so the serial register holds the sum of `by` consecutive rows.
- R3: Each super pixel is produced by one `node_rst` pulse, then exactly `bx` horizontal pulses, then one `convert` strobe. The digitized value is the sum of `bx` by `by` physical pixels.
- R4: One frame reads every enabled region in index order, each with its own bin factors. When a region starts below the current row, the rows in between get one vertical pulse each and are then flushed with `cfg_cols` horizontal pulses without conversion.
- R5: On every binned row, the `col0` columns before a region and the columns after its last group are shifted out with horizontal pulses and no `convert`. The row uses `cfg_cols` horizontal pulses in total.
- R6: A bin factor of 0 behaves exactly like a bin factor of 1.
- R7: Each of `vshift`, `hshift` and `node_rst` stays high for exactly `cfg_pulse_w` cycles per pulse, with 0 treated as 1. At most one of the pulse outputs and `convert` is high in any cycle, and at least one all-low cycle separates two pulses.
- R8: `convert` is one cycle wide. Between the last horizontal pulse of a group and its `convert`, at least `cfg_settle` cycles pass with every pulse output low.
- R9: If an enabled region has zero binned rows or columns, extends past `cfg_rows`/`cfg_cols`, or starts above the end of an earlier enabled region, then `start` raises `cfg_err`, no pulse or convert is issued, and `frame_done` still pulses. A later `start` with valid settings clears `cfg_err`.
- R10: `spix_count` is cleared by an accepted `start` and rises by one on each `convert`, so at frame end it equals the number of super pixels.
- R11: `frame_done` is high for one cycle after the last pulse of the frame, and no pulse follows it until the next `start`.
- R12: A `start` that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one frame readout (one-cycle pulse) |
| cfg_rows | input | W | Physical rows of the array |
| cfg_cols | input | W | Physical columns of the array |
| cfg_pulse_w | input | PW_W | Shift/reset pulse width in clock cycles (0 acts as 1) |
| cfg_settle | input | PW_W | Minimum quiet cycles before a convert |
| roi_en | input | NUM_ROI | Enable for each region |
| roi_row0 | input | NUM_ROI x W | First physical row of each region |
| roi_nsrows | input | NUM_ROI x W | Binned rows of each region |
| roi_col0 | input | NUM_ROI x W | First physical column of each region |
| roi_nscols | input | NUM_ROI x W | Binned columns of each region |
| roi_bx | input | NUM_ROI x BW | Horizontal bin factor of each region |
| roi_by | input | NUM_ROI x BW | Vertical bin factor of each region |
| vshift | output | 1 | Vertical (parallel) shift pulse |
| hshift | output | 1 | Horizontal (serial) shift pulse |
| node_rst | output | 1 | Output-node reset pulse |
| convert | output | 1 | Digitizer convert strobe |
| frame_done | output | 1 | One-cycle end-of-frame flag |
| cfg_err | output | 1 | Last start was rejected for bad region settings |
| spix_count | output | CNT_W | Super pixels converted in the current or last frame |

## Verification
A charge-counting model of the array gives every pixel a distinct value and sums charge as the pulses arrive. Each converted value is then compared with the expected bx-by-by sum, and a wrong count of vertical or horizontal pulses, or a missing node reset, shows up as a wrong number. The patterns are: a single 2x2 region over a 4x4 array; two regions with different factors, skipped rows and margins on both sides; zero bin factors with the smallest pulse width and no settle; overlapping and out-of-bounds regions; and a second start inside a running frame. Together they separate correct binning from miscounted groups, unflushed skip rows, converted margin columns, mishandled zero factors and restarts.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    // kind of pulse requested from the pulse generator
    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_V    = 2'd1,
        PK_H    = 2'd2,
        PK_R    = 2'd3
    } pulse_kind_e;

    // readout sequencer states
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_NEXT   = 4'd1,
        ST_SKIPV  = 4'd2,
        ST_FLUSH  = 4'd3,
        ST_ROWV   = 4'd4,
        ST_LEAD   = 4'd5,
        ST_RST    = 4'd6,
        ST_BINH   = 4'd7,
        ST_SETTLE = 4'd8,
        ST_CONV   = 4'd9,
        ST_TRAIL  = 4'd10,
        ST_ROWEND = 4'd11,
        ST_DONE   = 4'd12
    } seq_state_e;

endpackage

// File: rtl/ccd_pulse_gen.sv
module ccd_pulse_gen
    import ccd_seq_pkg::*;
#(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  pulse_kind_e     kind,
    input  logic [PW_W-1:0] width,
    output logic            vshift,
    output logic            hshift,
    output logic            node_rst,
    output logic            pulse_done
);

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_HIGH = 2'd1,
        PG_GAP  = 2'd2
    } pg_state_e;

    typedef struct packed {
        pg_state_e   st;
        pulse_kind_e kind;
        logic [PW_W-1:0] cnt;
    } pg_t;

    pg_t pg_q, pg_d;
    logic [PW_W-1:0] width_n;

    always_comb begin
        width_n = (width == '0) ? PW_W'(1) : width;
        pg_d    = pg_q;
        case (pg_q.st)
            PG_IDLE: begin
                if (req) begin
                    pg_d.st   = PG_HIGH;
                    pg_d.kind = kind;
                    pg_d.cnt  = width_n;
                end
            end
            PG_HIGH: begin
                if (pg_q.cnt == PW_W'(1)) begin
                    pg_d.st = PG_GAP;
                end else begin
                    pg_d.cnt = pg_q.cnt - PW_W'(1);
                end
            end
            PG_GAP:  pg_d.st = PG_IDLE;
            default: pg_d.st = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q.st   <= PG_IDLE;
            pg_q.kind <= PK_NONE;
            pg_q.cnt  <= '0;
        end else begin
            pg_q <= pg_d;
        end
    end

    assign vshift     = (pg_q.st == PG_HIGH) && (pg_q.kind == PK_V);
    assign hshift     = (pg_q.st == PG_HIGH) && (pg_q.kind == PK_H);
    assign node_rst   = (pg_q.st == PG_HIGH) && (pg_q.kind == PK_R);
    assign pulse_done = (pg_q.st == PG_GAP);

endmodule

// File: rtl/ccd_roi_pick.sv
module ccd_roi_pick #(
    parameter int NUM_ROI = 2,
    parameter int W       = 8,
    parameter int BW      = 4,
    parameter int IDX_W   = 2
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_ROI-1:0]        roi_en,
    input  logic [NUM_ROI-1:0][W-1:0] roi_row0,
    input  logic [NUM_ROI-1:0][W-1:0] roi_nsrows,
    input  logic [NUM_ROI-1:0][W-1:0] roi_col0,
    input  logic [NUM_ROI-1:0][W-1:0] roi_nscols,
    input  logic [NUM_ROI-1:0][BW-1:0] roi_bx,
    input  logic [NUM_ROI-1:0][BW-1:0] roi_by,
    output logic              s_en,
    output logic [W-1:0]      s_row0,
    output logic [W-1:0]      s_nsr,
    output logic [W-1:0]      s_col0,
    output logic [W-1:0]      s_nsc,
    output logic [BW-1:0]     s_bx,
    output logic [BW-1:0]     s_by
);

    logic [NUM_ROI-1:0][BW-1:0] bx_n, by_n;

    // a zero bin factor acts as one
    for (genvar k = 0; k < NUM_ROI; k++) begin : g_norm
        assign bx_n[k] = (roi_bx[k] == '0) ? BW'(1) : roi_bx[k];
        assign by_n[k] = (roi_by[k] == '0) ? BW'(1) : roi_by[k];
    end

    always_comb begin
        s_en   = 1'b0;
        s_row0 = '0;
        s_nsr  = '0;
        s_col0 = '0;
        s_nsc  = '0;
        s_bx   = BW'(1);
        s_by   = BW'(1);
        for (int k = 0; k < NUM_ROI; k++) begin
            if (idx == IDX_W'(k)) begin
                s_en   = roi_en[k];
                s_row0 = roi_row0[k];
                s_nsr  = roi_nsrows[k];
                s_col0 = roi_col0[k];
                s_nsc  = roi_nscols[k];
                s_bx   = bx_n[k];
                s_by   = by_n[k];
            end
        end
    end

endmodule

// File: rtl/ccd_roi_check.sv
module ccd_roi_check #(
    parameter int NUM_ROI = 2,
    parameter int W       = 8,
    parameter int BW      = 4
) (
    input  logic [W-1:0]               cfg_rows,
    input  logic [W-1:0]               cfg_cols,
    input  logic [NUM_ROI-1:0]         roi_en,
    input  logic [NUM_ROI-1:0][W-1:0]  roi_row0,
    input  logic [NUM_ROI-1:0][W-1:0]  roi_nsrows,
    input  logic [NUM_ROI-1:0][W-1:0]  roi_col0,
    input  logic [NUM_ROI-1:0][W-1:0]  roi_nscols,
    input  logic [NUM_ROI-1:0][BW-1:0] roi_bx,
    input  logic [NUM_ROI-1:0][BW-1:0] roi_by,
    output logic                       cfg_ok
);

    localparam int EW = W + BW + 1;

    logic [NUM_ROI-1:0][EW-1:0] row_end;
    logic [NUM_ROI-1:0][EW-1:0] col_end;
    logic [NUM_ROI-1:0]         local_bad;

    for (genvar k = 0; k < NUM_ROI; k++) begin : g_roi
        logic [BW-1:0] bxn, byn;
        assign bxn = (roi_bx[k] == '0) ? BW'(1) : roi_bx[k];
        assign byn = (roi_by[k] == '0) ? BW'(1) : roi_by[k];
        assign row_end[k] = EW'(roi_row0[k]) + EW'(roi_nsrows[k]) * EW'(byn);
        assign col_end[k] = EW'(roi_col0[k]) + EW'(roi_nscols[k]) * EW'(bxn);
        assign local_bad[k] = roi_en[k] &&
                              ((roi_nsrows[k] == '0) || (roi_nscols[k] == '0) ||
                               (row_end[k] > EW'(cfg_rows)) ||
                               (col_end[k] > EW'(cfg_cols)));
    end

    // ordering: each enabled region starts at or below the end of the previous one
    always_comb begin
        logic [EW-1:0] prev_end;
        prev_end = '0;
        cfg_ok   = 1'b1;
        for (int k = 0; k < NUM_ROI; k++) begin
            if (roi_en[k]) begin
                if (local_bad[k] || (EW'(roi_row0[k]) < prev_end)) begin
                    cfg_ok = 1'b0;
                end
                prev_end = row_end[k];
            end
        end
    end

endmodule

// File: rtl/ccd_bin_seq.sv
module ccd_bin_seq
    import ccd_seq_pkg::*;
#(
    parameter int NUM_ROI = 2,
    parameter int W       = 8,
    parameter int BW      = 4,
    parameter int PW_W    = 8,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [W-1:0]               cfg_rows,
    input  logic [W-1:0]               cfg_cols,
    input  logic [PW_W-1:0]            cfg_pulse_w,
    input  logic [PW_W-1:0]            cfg_settle,
    input  logic [NUM_ROI-1:0]         roi_en,
    input  logic [NUM_ROI-1:0][W-1:0]  roi_row0,
    input  logic [NUM_ROI-1:0][W-1:0]  roi_nsrows,
    input  logic [NUM_ROI-1:0][W-1:0]  roi_col0,
    input  logic [NUM_ROI-1:0][W-1:0]  roi_nscols,
    input  logic [NUM_ROI-1:0][BW-1:0] roi_bx,
    input  logic [NUM_ROI-1:0][BW-1:0] roi_by,
    output logic                       vshift,
    output logic                       hshift,
    output logic                       node_rst,
    output logic                       convert,
    output logic                       frame_done,
    output logic                       cfg_err,
    output logic [CNT_W-1:0]           spix_count
);

    localparam int EW    = W + BW + 1;
    localparam int IDX_W = $clog2(NUM_ROI + 1);

    typedef struct packed {
        seq_state_e       st;
        logic             wait_pg;
        logic [EW-1:0]    cnt;
        logic [EW-1:0]    cur_row;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     sr;
        logic [W-1:0]     sc;
        logic [CNT_W-1:0] pix;
        logic             err;
    } seq_t;

    seq_t q, d;

    logic          cfg_ok;
    logic          s_en;
    logic [W-1:0]  s_row0, s_nsr, s_col0, s_nsc;
    logic [BW-1:0] s_bx, s_by;
    logic [EW-1:0] s_rows_cov, s_col_end, s_trail;

    logic          pg_req, pg_done, last;
    pulse_kind_e   pg_kind;

    ccd_roi_check #(.NUM_ROI(NUM_ROI), .W(W), .BW(BW)) u_check (
        .cfg_rows   (cfg_rows),
        .cfg_cols   (cfg_cols),
        .roi_en     (roi_en),
        .roi_row0   (roi_row0),
        .roi_nsrows (roi_nsrows),
        .roi_col0   (roi_col0),
        .roi_nscols (roi_nscols),
        .roi_bx     (roi_bx),
        .roi_by     (roi_by),
        .cfg_ok     (cfg_ok)
    );

    ccd_roi_pick #(.NUM_ROI(NUM_ROI), .W(W), .BW(BW), .IDX_W(IDX_W)) u_pick (
        .idx        (q.idx),
        .roi_en     (roi_en),
        .roi_row0   (roi_row0),
        .roi_nsrows (roi_nsrows),
        .roi_col0   (roi_col0),
        .roi_nscols (roi_nscols),
        .roi_bx     (roi_bx),
        .roi_by     (roi_by),
        .s_en       (s_en),
        .s_row0     (s_row0),
        .s_nsr      (s_nsr),
        .s_col0     (s_col0),
        .s_nsc      (s_nsc),
        .s_bx       (s_bx),
        .s_by       (s_by)
    );

    ccd_pulse_gen #(.PW_W(PW_W)) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (pg_req),
        .kind       (pg_kind),
        .width      (cfg_pulse_w),
        .vshift     (vshift),
        .hshift     (hshift),
        .node_rst   (node_rst),
        .pulse_done (pg_done)
    );

    assign s_rows_cov = EW'(s_nsr) * EW'(s_by);
    assign s_col_end  = EW'(s_col0) + EW'(s_nsc) * EW'(s_bx);
    assign s_trail    = EW'(cfg_cols) - s_col_end;

    always_comb begin
        d       = q;
        pg_req  = 1'b0;
        pg_kind = PK_NONE;
        last    = 1'b0;

        // kind of pulse each pulse-issuing state asks for
        case (q.st)
            ST_SKIPV, ST_ROWV:                    pg_kind = PK_V;
            ST_FLUSH, ST_LEAD, ST_BINH, ST_TRAIL: pg_kind = PK_H;
            ST_RST:                               pg_kind = PK_R;
            default:                              pg_kind = PK_NONE;
        endcase

        // common pulse stepping: request, wait for the gap cycle, count down
        if (pg_kind != PK_NONE) begin
            if (!q.wait_pg) begin
                pg_req    = 1'b1;
                d.wait_pg = 1'b1;
            end else if (pg_done) begin
                d.wait_pg = 1'b0;
                d.cnt     = q.cnt - EW'(1);
                last      = (q.cnt == EW'(1));
            end
        end

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.pix     = '0;
                    d.cur_row = '0;
                    d.idx     = '0;
                    d.wait_pg = 1'b0;
                    d.err     = !cfg_ok;
                    d.st      = cfg_ok ? ST_NEXT : ST_DONE;
                end
            end
            ST_NEXT: begin
                if (q.idx == IDX_W'(NUM_ROI)) begin
                    d.st = ST_DONE;
                end else if (!s_en) begin
                    d.idx = q.idx + IDX_W'(1);
                end else begin
                    d.sr = '0;
                    if (EW'(s_row0) > q.cur_row) begin
                        d.cnt = EW'(s_row0) - q.cur_row;
                        d.st  = ST_SKIPV;
                    end else begin
                        d.cnt = EW'(s_by);
                        d.st  = ST_ROWV;
                    end
                end
            end
            ST_SKIPV: begin
                if (last) begin
                    d.cnt = EW'(cfg_cols);
                    d.st  = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (last) begin
                    d.cnt = EW'(s_by);
                    d.st  = ST_ROWV;
                end
            end
            ST_ROWV: begin
                if (last) begin
                    d.sc = '0;
                    if (s_col0 != '0) begin
                        d.cnt = EW'(s_col0);
                        d.st  = ST_LEAD;
                    end else begin
                        d.cnt = EW'(1);
                        d.st  = ST_RST;
                    end
                end
            end
            ST_LEAD: begin
                if (last) begin
                    d.cnt = EW'(1);
                    d.st  = ST_RST;
                end
            end
            ST_RST: begin
                if (last) begin
                    d.cnt = EW'(s_bx);
                    d.st  = ST_BINH;
                end
            end
            ST_BINH: begin
                if (last) begin
                    d.cnt = EW'(cfg_settle);
                    d.st  = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (q.cnt == '0) begin
                    d.st = ST_CONV;
                end else begin
                    d.cnt = q.cnt - EW'(1);
                end
            end
            ST_CONV: begin
                d.pix = q.pix + CNT_W'(1);
                d.sc  = q.sc + W'(1);
                if (q.sc + W'(1) == s_nsc) begin
                    if (s_trail != '0) begin
                        d.cnt = s_trail;
                        d.st  = ST_TRAIL;
                    end else begin
                        d.st = ST_ROWEND;
                    end
                end else begin
                    d.cnt = EW'(1);
                    d.st  = ST_RST;
                end
            end
            ST_TRAIL: begin
                if (last) begin
                    d.st = ST_ROWEND;
                end
            end
            ST_ROWEND: begin
                d.sr = q.sr + W'(1);
                if (q.sr + W'(1) == s_nsr) begin
                    d.cur_row = EW'(s_row0) + s_rows_cov;
                    d.idx     = q.idx + IDX_W'(1);
                    d.st      = ST_NEXT;
                end else begin
                    d.cnt = EW'(s_by);
                    d.st  = ST_ROWV;
                end
            end
            ST_DONE:  d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.wait_pg <= 1'b0;
            q.cnt     <= '0;
            q.cur_row <= '0;
            q.idx     <= '0;
            q.sr      <= '0;
            q.sc      <= '0;
            q.pix     <= '0;
            q.err     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign convert    = (q.st == ST_CONV);
    assign frame_done = (q.st == ST_DONE);
    assign cfg_err    = q.err;
    assign spix_count = q.pix;

endmodule

// File: rtl/ccd_bin_seq_chk.sv
module ccd_bin_seq_chk #(
    parameter int PW_W  = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [PW_W-1:0]  cfg_pulse_w,
    input logic             vshift,
    input logic             hshift,
    input logic             node_rst,
    input logic             convert,
    input logic             frame_done,
    input logic             cfg_err,
    input logic [CNT_W-1:0] spix_count
);

    logic            any_pulse;
    logic [PW_W:0]   run_q;
    logic [PW_W:0]   width_exp;

    assign any_pulse = vshift | hshift | node_rst;
    assign width_exp = (cfg_pulse_w == '0) ? (PW_W+1)'(1) : {1'b0, cfg_pulse_w};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (any_pulse) begin
            run_q <= run_q + (PW_W+1)'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R7: a finished pulse lasted exactly the programmed width
    always_ff @(posedge clk) begin
        if (rst_n && !any_pulse && run_q != '0) begin
            p_pulse_width_r7: assert (run_q == width_exp)
                else $error("pulse width %0d, expected %0d", run_q, width_exp);
        end
    end

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vshift, hshift, node_rst, convert}));

    p_conv_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        convert |=> !convert);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !(vshift || hshift || node_rst || convert));

    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        convert |=> (spix_count == $past(spix_count) + CNT_W'(1)));

    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!convert && !start) |=> $stable(spix_count));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !(vshift || hshift || node_rst || convert));

endmodule

bind ccd_bin_seq ccd_bin_seq_chk #(.PW_W(PW_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_pulse_w (cfg_pulse_w),
    .vshift      (vshift),
    .hshift      (hshift),
    .node_rst    (node_rst),
    .convert     (convert),
    .frame_done  (frame_done),
    .cfg_err     (cfg_err),
    .spix_count  (spix_count)
);

// File: tb/ccd_bin_seq_test.sv
`timescale 1ns/1ps
module ccd_bin_seq_test;

    localparam int NR = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cfg_rows = 8'd4, cfg_cols = 8'd4;
    logic [7:0] cfg_pulse_w = 8'd2, cfg_settle = 8'd3;
    logic [NR-1:0] roi_en = '0;
    logic [NR-1:0][7:0] roi_row0 = '0, roi_nsrows = '0, roi_col0 = '0, roi_nscols = '0;
    logic [NR-1:0][3:0] roi_bx = '0, roi_by = '0;
    logic vshift, hshift, node_rst, convert, frame_done, cfg_err;
    logic [15:0] spix_count;

    always #4 clk = ~clk;

    ccd_bin_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
        .cfg_pulse_w(cfg_pulse_w), .cfg_settle(cfg_settle),
        .roi_en(roi_en), .roi_row0(roi_row0), .roi_nsrows(roi_nsrows),
        .roi_col0(roi_col0), .roi_nscols(roi_nscols),
        .roi_bx(roi_bx), .roi_by(roi_by),
        .vshift(vshift), .hshift(hshift), .node_rst(node_rst),
        .convert(convert), .frame_done(frame_done), .cfg_err(cfg_err),
        .spix_count(spix_count)
    );

    int total = 0;
    int bad = 0;

    // charge model of the array
    int pix [16][16];
    int hreg [16];
    int node;
    int got [64];
    int ngot, nv, nh, nr;
    int width_bad, gap_bad, settle_bad, conv_bad, done_cnt, done_twice;
    int hi_run, low_after_h;
    logic pv, ph, pr, pc, pd;

    int exp_val [64];
    int exp_n, exp_nv, exp_nh;

    function automatic int pval(int r, int c);
        return 1 + r * 20 + c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_load();
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                pix[r][c] = (r < int'(cfg_rows) && c < int'(cfg_cols)) ? pval(r, c) : 0;
        for (int c = 0; c < 16; c++) hreg[c] = 0;
        node = 0; ngot = 0; nv = 0; nh = 0; nr = 0;
        width_bad = 0; gap_bad = 0; settle_bad = 0; conv_bad = 0;
        done_cnt = 0; done_twice = 0; hi_run = 0; low_after_h = 1000;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int pwn;
            pwn = (cfg_pulse_w == 0) ? 1 : int'(cfg_pulse_w);
            if (vshift && !pv) begin
                nv++;
                for (int c = 0; c < 16; c++) hreg[c] += pix[0][c];
                for (int r = 0; r < 15; r++)
                    for (int c = 0; c < 16; c++) pix[r][c] = pix[r+1][c];
                for (int c = 0; c < 16; c++) pix[15][c] = 0;
            end
            if (hshift && !ph) begin
                nh++;
                node += hreg[0];
                for (int c = 0; c < 15; c++) hreg[c] = hreg[c+1];
                hreg[15] = 0;
            end
            if (node_rst && !pr) begin
                nr++;
                node = 0;
            end
            if ((vshift && (ph || pr)) || (hshift && (pv || pr)) || (node_rst && (pv || ph)))
                gap_bad++;
            if (vshift || hshift || node_rst) hi_run++;
            else if (hi_run != 0) begin
                if (hi_run != pwn) width_bad++;
                hi_run = 0;
            end
            if (convert) begin
                if (pc || vshift || hshift || node_rst) conv_bad++;
                if (low_after_h < int'(cfg_settle)) settle_bad++;
                if (ngot < 64) got[ngot] = node;
                ngot++;
            end
            if (hshift) low_after_h = 0;
            else if (!vshift && !node_rst) low_after_h++;
            if (frame_done) begin
                done_cnt++;
                if (pd) done_twice++;
            end
            pv = vshift; ph = hshift; pr = node_rst; pc = convert; pd = frame_done;
        end else begin
            pv = 0; ph = 0; pr = 0; pc = 0; pd = 0;
        end
    end

    task automatic set_roi(input int k, input bit en, input int r0, input int nsr,
                           input int c0, input int nsc, input int bx, input int by);
        roi_en[k] = en;
        roi_row0[k] = 8'(r0); roi_nsrows[k] = 8'(nsr);
        roi_col0[k] = 8'(c0); roi_nscols[k] = 8'(nsc);
        roi_bx[k] = 4'(bx); roi_by[k] = 4'(by);
    endtask

    // expected super pixels and pulse counts from the region settings
    task automatic compute_expect();
        int cur;
        exp_n = 0; exp_nv = 0; exp_nh = 0; cur = 0;
        for (int k = 0; k < NR; k++) begin
            if (roi_en[k]) begin
                int bx, by, r0;
                bx = (roi_bx[k] == 0) ? 1 : int'(roi_bx[k]);
                by = (roi_by[k] == 0) ? 1 : int'(roi_by[k]);
                r0 = int'(roi_row0[k]);
                if (r0 > cur) exp_nh += int'(cfg_cols);
                for (int s = 0; s < int'(roi_nsrows[k]); s++) begin
                    exp_nh += int'(cfg_cols);
                    for (int g = 0; g < int'(roi_nscols[k]); g++) begin
                        int sum;
                        sum = 0;
                        for (int i = 0; i < by; i++)
                            for (int j = 0; j < bx; j++)
                                sum += pval(r0 + s * by + i, int'(roi_col0[k]) + g * bx + j);
                        exp_val[exp_n] = sum;
                        exp_n++;
                    end
                end
                cur = r0 + int'(roi_nsrows[k]) * by;
            end
        end
        exp_nv = cur;
    endtask

    // run one frame; returns whether frame_done was seen
    task automatic run_frame(input int restart_at, output bit seen);
        int i;
        model_load();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        seen = frame_done;
        i = 0;
        while (!seen && i < 20000) begin
            start = (i == restart_at);
            @(negedge clk); #1;
            seen = frame_done;
            i++;
        end
        start = 1'b0;
        repeat (6) @(negedge clk);
        #1;
    endtask

    task automatic check_frame(input string tag);
        chk(ngot == exp_n, {tag, " R10 convert count"}, ngot, exp_n);
        chk(int'(spix_count) == exp_n, {tag, " R10 spix_count"}, int'(spix_count), exp_n);
        for (int n = 0; n < exp_n && n < ngot && n < 64; n++)
            chk(got[n] == exp_val[n], {tag, " R3 super pixel sum"}, got[n], exp_val[n]);
        chk(nv == exp_nv, {tag, " R2 vertical pulse count"}, nv, exp_nv);
        chk(nh == exp_nh, {tag, " R5 horizontal pulse count"}, nh, exp_nh);
        chk(nr == exp_n, {tag, " R3 node reset count"}, nr, exp_n);
        chk(width_bad == 0 && gap_bad == 0, {tag, " R7 pulse width/gap"}, width_bad + gap_bad, 0);
        chk(settle_bad == 0 && conv_bad == 0, {tag, " R8 settle/convert"}, settle_bad + conv_bad, 0);
        chk(done_cnt == 1 && done_twice == 0, {tag, " R11 single done"}, done_cnt, 1);
        chk(cfg_err == 1'b0, {tag, " R9 no cfg_err"}, int'(cfg_err), 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk({vshift, hshift, node_rst, convert, frame_done, cfg_err} == 6'b0,
            "R1 outputs low after reset", int'({vshift, hshift, node_rst, convert, frame_done, cfg_err}), 0);
        chk(spix_count == 16'd0, "R1 count zero after reset", int'(spix_count), 0);
    endtask

    task automatic test_single_2x2();
        bit seen;
        cfg_rows = 8'd4; cfg_cols = 8'd4; cfg_pulse_w = 8'd2; cfg_settle = 8'd3;
        set_roi(0, 1, 0, 2, 0, 2, 2, 2);
        set_roi(1, 0, 0, 0, 0, 0, 0, 0);
        compute_expect();
        run_frame(-1, seen);
        chk(seen, "R11 done seen (2x2)", int'(seen), 1);
        chk(exp_n == 4, "R3 2x2 on 4x4 gives four super pixels", exp_n, 4);
        check_frame("2x2");
    endtask

    task automatic test_two_regions();
        bit seen;
        cfg_rows = 8'd8; cfg_cols = 8'd8; cfg_pulse_w = 8'd3; cfg_settle = 8'd4;
        set_roi(0, 1, 1, 1, 1, 2, 3, 2);
        set_roi(1, 1, 5, 3, 2, 5, 1, 1);
        compute_expect();
        run_frame(-1, seen);
        chk(seen, "R4 done seen (two regions)", int'(seen), 1);
        check_frame("R4 two regions");
    endtask

    task automatic test_zero_bins();
        bit seen;
        cfg_rows = 8'd3; cfg_cols = 8'd3; cfg_pulse_w = 8'd0; cfg_settle = 8'd0;
        set_roi(0, 1, 0, 2, 1, 2, 0, 0);
        set_roi(1, 0, 0, 0, 0, 0, 0, 0);
        compute_expect();
        run_frame(-1, seen);
        chk(seen, "R6 done seen (zero bins)", int'(seen), 1);
        check_frame("R6 zero bins");
    endtask

    task automatic test_cfg_errors();
        bit seen;
        cfg_rows = 8'd8; cfg_cols = 8'd8; cfg_pulse_w = 8'd2; cfg_settle = 8'd1;
        // overlapping: region 1 starts inside region 0
        set_roi(0, 1, 0, 2, 0, 2, 2, 2);
        set_roi(1, 1, 3, 1, 0, 2, 1, 1);
        run_frame(-1, seen);
        chk(seen, "R9 done after overlap error", int'(seen), 1);
        chk(cfg_err == 1'b1, "R9 cfg_err on overlap", int'(cfg_err), 1);
        chk(nv + nh + nr + ngot == 0, "R9 no pulses on overlap", nv + nh + nr + ngot, 0);
        chk(spix_count == 16'd0, "R9 count zero on error", int'(spix_count), 0);
        // columns past the array edge
        set_roi(0, 1, 0, 1, 4, 3, 2, 1);
        set_roi(1, 0, 0, 0, 0, 0, 0, 0);
        run_frame(-1, seen);
        chk(cfg_err == 1'b1, "R9 cfg_err on column overflow", int'(cfg_err), 1);
        chk(nv + nh + nr + ngot == 0, "R9 no pulses on overflow", nv + nh + nr + ngot, 0);
        // valid settings clear the flag
        set_roi(0, 1, 2, 1, 4, 2, 2, 1);
        compute_expect();
        run_frame(-1, seen);
        check_frame("R9 recovery");
    endtask

    task automatic test_restart_ignored();
        bit seen;
        cfg_rows = 8'd8; cfg_cols = 8'd8; cfg_pulse_w = 8'd1; cfg_settle = 8'd2;
        set_roi(0, 1, 1, 1, 1, 2, 3, 2);
        set_roi(1, 1, 5, 3, 2, 5, 1, 1);
        compute_expect();
        run_frame(60, seen);
        chk(seen, "R12 done seen with restart", int'(seen), 1);
        check_frame("R12 restart ignored");
    endtask

    initial begin
        #(8 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=0 expected=1 (run did not finish)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_single_2x2();
        test_two_regions();
        test_zero_bins();
        test_cfg_errors();
        test_restart_ignored();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule